// File: doc/BRIEF.md
# DMA Channel Event Status and Interrupt Register

This block holds the event status and interrupt mask of one DMA channel. It also holds the small run/halt sequencer that goes with them. The channel engine reports five kinds of event:

- normal completion
- error completion
- not-ready
- abort, found when a descriptor starts while the control abort bit is high
- premature fly-by end-of-transfer

Each event sets a sticky pending flag. Software clears a flag by writing 1 to it. Each flag has its own enable, and one level interrupt is raised while any enabled flag is pending.

An abort retires the current descriptor and halts the channel. The channel stays halted until software writes the channel-enable bit again. If the abort control bit is still high at that point, the next descriptor that starts is aborted too. A premature end-of-transfer in fly-by write mode sets its own flag and the normal-completion flag together, and the channel keeps running.

The register also shows, read-only, the active descriptor's flag bits and its remaining byte count.

Top module: `dma_chan_stat`

## Requirements
- R1: After reset, the status word reads 0 (with all debug inputs at 0), `irq_o` is 0 and `run_o` is 1.
- R2: A one-cycle strobe on `evt_done_i`, `evt_err_i` or `evt_nrdy_i` sets pending bit 31, 30 or 29 respectively after the next clock edge, and the bit stays set.
- R3: A write to the status address with 1 in any of bits 31:27 clears that pending bit. A 0 in those bits leaves the pending bit as it is.
- R4: When an event and a write-1-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R5: Bits 24:20 are read/write enables for done, error, not-ready, abort and premature, in that order. Bits 26:25 always read 0.
- R6: `irq_o` goes to 1 one cycle after a pending bit and its enable are both 1. It stays at 1 until no enabled bit is pending. A pending bit whose enable is 0 never raises it.
- R7: `desc_start_i` with `ctl_abort_i` high while running sets pending bit 28 and drops `run_o`. It also pulses `desc_abort_o` for exactly one cycle. All of these take effect after the next edge.
- R8: While halted, `run_o` stays 0 and `desc_start_i` has no effect. A `ctl_enable_wr_i` strobe restores `run_o` to 1 after the next edge.
- R9: If `ctl_abort_i` is still high after re-enabling, the next `desc_start_i` aborts again. With `ctl_abort_i` low, it does not abort.
- R10: `evt_eot_i` with `flyby_mode_i` and `desc_active_i` both high sets pending bits 27 and 31 and does not halt. Without fly-by mode or without an active descriptor, it changes nothing.
- R11: Bits 19, 18, 17 and 16 mirror the wrap, interrupt-on-done, last-in-frame and buffer-full inputs. Bits 15:0 mirror the remaining byte count. Writes do not affect these bits.
- R12: The status word is at address 0. Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| evt_done_i | input | 1 | Normal-completion strobe |
| evt_err_i | input | 1 | Error-completion strobe |
| evt_nrdy_i | input | 1 | Not-ready strobe |
| evt_eot_i | input | 1 | Peripheral end-of-transfer strobe |
| flyby_mode_i | input | 1 | Channel is in fly-by write mode |
| desc_active_i | input | 1 | A descriptor is in progress |
| desc_start_i | input | 1 | Engine begins a descriptor |
| ctl_abort_i | input | 1 | Abort bit of the control register |
| ctl_enable_wr_i | input | 1 | Software wrote 1 to the channel-enable bit |
| desc_wrap_i | input | 1 | Active descriptor: last in list |
| desc_idone_i | input | 1 | Active descriptor: interrupt on done |
| desc_last_i | input | 1 | Active descriptor: last in frame |
| desc_full_i | input | 1 | Active descriptor: buffer full |
| desc_blen_i | input | 16 | Remaining byte count |
| run_o | output | 1 | Channel may process descriptors |
| desc_abort_o | output | 1 | One-cycle pulse: retire the current descriptor |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check, on every cycle:
- an event strobe always leaves its pending bit set;
- a halted channel stays halted unless it is re-enabled;
- an abort always drops `run_o` and produces the retire pulse;
- the premature flag never rises without the completion flag;
- no enabled pending bit means no interrupt in the following cycle.

Only the bench scenarios can show the other behaviours:
- the full register image under mixed sequences of events and writes;
- the repeated abort when the control bit is left high;
- that a premature end-of-transfer is ignored outside fly-by mode;
- that writes to the debug fields and to other addresses are ignored.

// File: rtl/dma_chan_stat_pkg.sv
package dma_chan_stat_pkg;
  localparam int N_EV    = 5;
  // event index; pending bit = PEND_LSB+idx, enable bit = EN_LSB+idx
  localparam int EV_PREM = 0;
  localparam int EV_ABRT = 1;
  localparam int EV_NRDY = 2;
  localparam int EV_ERR  = 3;
  localparam int EV_DONE = 4;
  localparam int PEND_LSB = 27;
  localparam int EN_LSB   = 20;
  localparam int BLEN_W   = 16;
  localparam int DATA_W   = 32;
endpackage

// File: rtl/dma_pend_bank.sv
module dma_pend_bank #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[i] <= 1'b0;
      else         pend_q[i] <= set_i[i] | (pend_q[i] & ~clr_i[i]);  // set beats clear
    end

    // R4
    set_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> pend_q[i]);
    // R3
    clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !pend_q[i]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dma_halt_seq.sv
module dma_halt_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic desc_start_i,
  input  logic ctl_abort_i,
  input  logic ctl_enable_wr_i,
  output logic abort_hit_o,
  output logic run_o,
  output logic desc_abort_o
);
  logic run_q, abort_q;

  assign abort_hit_o = desc_start_i & ctl_abort_i & run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b1;
      abort_q <= 1'b0;
    end else begin
      abort_q <= abort_hit_o;
      if (abort_hit_o)          run_q <= 1'b0;
      else if (ctl_enable_wr_i) run_q <= 1'b1;
    end
  end

  assign run_o        = run_q;
  assign desc_abort_o = abort_q;

  // R7
  abort_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_start_i && ctl_abort_i && run_o) |=> (!run_o && desc_abort_o));
  // R8
  halt_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !ctl_enable_wr_i) |=> (!run_o && !desc_abort_o));
endmodule

// File: rtl/dma_irq_mask.sv
module dma_irq_mask #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_i & en_i);
  end

  assign irq_o = irq_q;

  // R6
  no_spurious_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & en_i) == '0) |=> !irq_o);
endmodule

// File: rtl/dma_chan_stat.sv
module dma_chan_stat
  import dma_chan_stat_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              evt_done_i,
  input  logic              evt_err_i,
  input  logic              evt_nrdy_i,
  input  logic              evt_eot_i,
  input  logic              flyby_mode_i,
  input  logic              desc_active_i,
  input  logic              desc_start_i,
  input  logic              ctl_abort_i,
  input  logic              ctl_enable_wr_i,
  input  logic              desc_wrap_i,
  input  logic              desc_idone_i,
  input  logic              desc_last_i,
  input  logic              desc_full_i,
  input  logic [BLEN_W-1:0] desc_blen_i,
  output logic              run_o,
  output logic              desc_abort_o,
  output logic              irq_o
);
  localparam int GAP_W = PEND_LSB - EN_LSB - N_EV;

  logic              sel, wr_hit, abort_hit, prem_hit;
  logic [N_EV-1:0]   ev_set, ev_clr, pend, en_q;

  assign sel      = (reg_addr_i == STAT_ADDR);
  assign wr_hit   = reg_wr_i & sel;
  assign prem_hit = evt_eot_i & flyby_mode_i & desc_active_i;

  always_comb begin
    ev_set          = '0;
    ev_set[EV_DONE] = evt_done_i | prem_hit;  // premature also flags completion
    ev_set[EV_ERR]  = evt_err_i;
    ev_set[EV_NRDY] = evt_nrdy_i;
    ev_set[EV_ABRT] = abort_hit;
    ev_set[EV_PREM] = prem_hit;
    ev_clr = wr_hit ? reg_wdata_i[PEND_LSB +: N_EV] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= '0;
    else if (wr_hit) en_q <= reg_wdata_i[EN_LSB +: N_EV];
  end

  dma_pend_bank #(.N(N_EV)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ev_set),
    .clr_i  (ev_clr),
    .pend_o (pend)
  );

  dma_halt_seq u_halt (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .desc_start_i    (desc_start_i),
    .ctl_abort_i     (ctl_abort_i),
    .ctl_enable_wr_i (ctl_enable_wr_i),
    .abort_hit_o     (abort_hit),
    .run_o           (run_o),
    .desc_abort_o    (desc_abort_o)
  );

  dma_irq_mask #(.N(N_EV)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .en_i   (en_q),
    .irq_o  (irq_o)
  );

  assign reg_rdata_o = sel ? {pend, {GAP_W{1'b0}}, en_q, desc_wrap_i, desc_idone_i,
                              desc_last_i, desc_full_i, desc_blen_i} : '0;

  // R10
  prem_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend[EV_PREM]) |-> pend[EV_DONE]);
  // R12
  foreign_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !sel) |=> $stable(en_q));
endmodule

// File: tb/dma_chan_stat_test.sv
module dma_chan_stat_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic ev_done = 0, ev_err = 0, ev_nrdy = 0, ev_eot = 0, flyby = 0, active = 0;
  logic start = 0, cabort = 0, cen = 0;
  logic d_wrap = 0, d_idone = 0, d_last = 0, d_full = 0;
  logic [15:0] d_blen = '0;
  logic run, dabort, irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dma_chan_stat uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .evt_done_i(ev_done), .evt_err_i(ev_err), .evt_nrdy_i(ev_nrdy), .evt_eot_i(ev_eot),
    .flyby_mode_i(flyby), .desc_active_i(active), .desc_start_i(start),
    .ctl_abort_i(cabort), .ctl_enable_wr_i(cen),
    .desc_wrap_i(d_wrap), .desc_idone_i(d_idone), .desc_last_i(d_last), .desc_full_i(d_full),
    .desc_blen_i(d_blen), .run_o(run), .desc_abort_o(dabort), .irq_o(irq));

  // {done,err,nrdy}, wr, wdata[31:20], expected rdata[31:20]
  localparam logic [27:0] VEC [10] = '{
    {3'b100, 1'b0, 12'h000, 12'h800},  // R2
    {3'b010, 1'b0, 12'h000, 12'hC00},  // R2
    {3'b001, 1'b0, 12'h000, 12'hE00},  // R2
    {3'b000, 1'b1, 12'h400, 12'hA00},  // R3
    {3'b000, 1'b1, 12'h01F, 12'hA1F},  // R5
    {3'b100, 1'b1, 12'h81F, 12'hA1F},  // R4
    {3'b000, 1'b1, 12'hA1F, 12'h01F},  // R3
    {3'b000, 1'b1, 12'h000, 12'h000},  // R5
    {3'b000, 1'b1, 12'h07F, 12'h01F},  // R5 bits 26:25 read 0
    {3'b010, 1'b1, 12'h01F, 12'h41F}   // R2
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    ev_done = 0; ev_err = 0; ev_nrdy = 0; ev_eot = 0; wr = 0;
    start = 0; cen = 0;
  endtask

  task automatic wreg(input logic [31:0] d);
    wdata = d; wr = 1'b1; step();
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 run", {31'b0, run}, 32'h1);

    for (int i = 0; i < 10; i++) begin
      {ev_done, ev_err, ev_nrdy} = VEC[i][27:25];
      wr = VEC[i][24];
      wdata = {VEC[i][23:12], 20'h0};
      step();
      chk($sformatf("R2-table vec%0d", i), {20'h0, rdata[31:20]}, {20'h0, VEC[i][11:0]});
    end

    // R6: err pending and enabled since last vector
    step();
    chk("R6 irq set", {31'b0, irq}, 32'h1);
    wreg(32'h41F0_0000);
    chk("R6 irq held one cycle", {31'b0, irq}, 32'h1);
    step();
    chk("R6 irq cleared", {31'b0, irq}, 32'h0);
    wreg(32'h0);
    ev_done = 1; step(); step();
    chk("R6 masked no irq", {31'b0, irq}, 32'h0);
    chk("R6 masked pending", {31'b0, rdata[31]}, 32'h1);
    wreg(32'h8000_0000);

    // R7 abort
    cabort = 1; start = 1; step();
    chk("R7 pend28", {31'b0, rdata[28]}, 32'h1);
    chk("R7 run low", {31'b0, run}, 32'h0);
    chk("R7 pulse", {31'b0, dabort}, 32'h1);
    start = 1; step();
    chk("R7 pulse single", {31'b0, dabort}, 32'h0);
    chk("R8 start ignored", {31'b0, run}, 32'h0);
    step();
    chk("R8 stays halted", {31'b0, run}, 32'h0);
    wreg(32'h1000_0000);
    chk("R3 abort clr", {31'b0, rdata[28]}, 32'h0);
    cen = 1; step();
    chk("R8 re-enabled", {31'b0, run}, 32'h1);
    start = 1; step();
    chk("R9 aborts again", {31'b0, run}, 32'h0);
    chk("R9 pulse again", {31'b0, dabort}, 32'h1);
    cabort = 0; cen = 1; step();
    start = 1; step();
    chk("R9 no abort when clear", {31'b0, run}, 32'h1);
    chk("R9 no pulse when clear", {31'b0, dabort}, 32'h0);
    wreg(32'hF800_0000);

    // R10 premature
    active = 1; flyby = 0; ev_eot = 1; step();
    chk("R10 not flyby", rdata, 32'h0);
    flyby = 1; active = 0; ev_eot = 1; step();
    chk("R10 not active", rdata, 32'h0);
    active = 1; ev_eot = 1; step();
    chk("R10 prem+done", {27'b0, rdata[31:27]}, 32'h11);
    chk("R10 keeps running", {31'b0, run}, 32'h1);
    wreg(32'hF800_0000);

    // R11 mirrors
    d_wrap = 1; d_idone = 0; d_last = 1; d_full = 0; d_blen = 16'hBEEF;
    wreg(32'h000F_0000);
    chk("R11 mirror", rdata, 32'h000A_BEEF);

    // R12 other address
    addr = 4'h1; wreg(32'hFFFF_FFFF);
    chk("R12 read zero", rdata, 32'h0);
    addr = 4'h0; #0;
    chk("R12 write ignored", rdata, 32'h000A_BEEF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule